// File: doc/BRIEF.md
# Two-Operand Addressing Mode Decoder

This block sits between instruction fetch and execute in a small 16-bit processor. It takes one two-address instruction word and resolves both operand fields. The source resolves to a register, a constant or an effective memory address. The destination resolves to a register or an effective memory address. Along the way it reads any extension words that follow the opcode, advances the program counter once for each word it reads, and writes back an auto-incremented base register. Performing the operation and writing the result are left to the execute stage.

The decoder is started with a one-cycle pulse while it is idle. On that pulse it captures the instruction and reads the program counter from register 0. By then the program counter must already point past the opcode. The decoder uses one combinational register-file read port, one register-file write port, and a memory read port with a request/valid handshake. That memory port tolerates any number of wait states.

Two source registers have special meaning. Register 3 always produces a constant. Register 2 produces a constant in its indirect modes and an absolute address in its indexed mode. Register 0 makes the indexed mode PC-relative and the auto-increment mode an immediate.

Top module: `operand_mode_decoder`

## Requirements
- R1: During and after reset the block is idle: busy_o, done_o, mem_req_o and rf_we_o are all 0.
- R2: Fields of the instruction word: source register is bits 11:8, source mode is bits 5:4, destination mode is bit 7, byte select is bit 6, destination register is bits 3:0. src_reg_o and dst_reg_o echo bits 11:8 and 3:0.
- R3: For a general source register (not 0, 2 or 3 where noted below), mode 0 gives src_kind_o=0 (register) with src_val_o=0. Mode 2 gives src_kind_o=2 (memory) with src_val_o equal to the register value. With register 0, mode 0 and mode 2 behave the same way, and mode 2 yields the current program counter as the address.
- R4: Source mode 3 on a general register gives kind 2 with the address set to the register's value before the increment. The register is then written back incremented by 1 when bit 6 is 1 and by 2 when it is 0.
- R5: Source mode 1 on a general register reads one extension word and gives kind 2 with the address set to the register value plus that word.
- R6: Source register 3 gives kind 1 (constant) with the value 0, 1, 2 or FFFF for modes 0, 1, 2 and 3. No memory read takes place.
- R7: Source register 2 gives kind 0 in mode 0. Mode 1 gives kind 2 with the extension word as the absolute address. Modes 2 and 3 give kind 1 with the constants 4 and 8.
- R8: Source register 0 in mode 1 gives kind 2 with the address equal to the extension word's own address plus the word. In mode 3 it gives kind 1 with the extension word as the value.
- R9: Destination mode 0 gives dst_kind_o=0 with dst_addr_o=0. Destination mode 1 reads an extension word and gives kind 2. For register 0 the address is the word's own address plus the word. For register 2 it is the word alone. For any other register it is the register value plus the word.
- R10: Each extension word is read at the current program counter. Each word read writes register 0 with the program counter plus 2. The source word is read before the destination word.
- R11: dst_wmask_o is 00FF when the destination is a register and bit 6 is 1, and FFFF otherwise.
- R12: done_o is a one-cycle pulse after all reads are finished, and the outputs are valid at that point. A start_i pulse while busy_o is 1 is ignored.
- R13: A destination that uses the same register as an auto-incremented source sees the incremented value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Begin decoding instr_i (accepted only when idle) |
| instr_i | input | 16 | Instruction word |
| busy_o | output | 1 | Decode in progress |
| done_o | output | 1 | One-cycle pulse: operand outputs valid |
| rf_raddr_o | output | 4 | Register file read index |
| rf_rdata_i | input | 16 | Register file read data (combinational) |
| rf_we_o | output | 1 | Register file write enable |
| rf_waddr_o | output | 4 | Register file write index |
| rf_wdata_o | output | 16 | Register file write data |
| mem_req_o | output | 1 | Extension word read request |
| mem_addr_o | output | 16 | Extension word byte address |
| mem_rvalid_i | input | 1 | Read data valid |
| mem_rdata_i | input | 16 | Read data |
| src_kind_o | output | 2 | Source kind: 0 register, 1 constant, 2 memory |
| src_reg_o | output | 4 | Source register field |
| src_val_o | output | 16 | Constant value or effective address |
| dst_kind_o | output | 2 | Destination kind: 0 register, 2 memory |
| dst_reg_o | output | 4 | Destination register field |
| dst_addr_o | output | 16 | Destination effective address |
| byte_o | output | 1 | Byte operation select |
| dst_wmask_o | output | 16 | Mask the writeback applies to a register destination |

## Verification
A stale copy of the program counter would show up on the second extension request of the same instruction. That request would go out at the wrong address, and the PC write-back would be off by two in the cycle the word arrives. A misrouted base register or a wrong increment step becomes visible at the register write port in the same cycle the source is decoded. A wrong mode classification shows up as a wrong kind, or as a missing or extra memory request, no later than the done pulse of that instruction. Running the same register as both the auto-incremented source and the indexed destination shows whether the write-back ordering is correct.

// File: rtl/opd_pkg.sv
package opd_pkg;
  typedef enum logic [1:0] {K_REG = 2'd0, K_CONST = 2'd1, K_MEM = 2'd2} opd_kind_e;
  typedef enum logic [2:0] {A_REG, A_CONST, A_IND, A_INC, A_IDX, A_ABS, A_IMM} opd_act_e;
  localparam int unsigned PC_IDX = 0;
  localparam int unsigned SR_IDX = 2;
  localparam int unsigned CG_IDX = 3;
endpackage

// File: rtl/opd_src_decode.sv
module opd_src_decode import opd_pkg::*; #(
  parameter int unsigned DW  = 16,
  parameter int unsigned RAW = 4
) (
  input  logic [RAW-1:0] reg_i,
  input  logic [1:0]     mode_i,
  output opd_act_e       act_o,
  output logic [DW-1:0]  cval_o
);
  always_comb begin
    act_o  = A_REG;
    cval_o = '0;
    if (reg_i == RAW'(CG_IDX)) begin
      act_o = A_CONST;
      unique case (mode_i)
        2'd0: cval_o = '0;
        2'd1: cval_o = DW'(1);
        2'd2: cval_o = DW'(2);
        default: cval_o = '1;
      endcase
    end else if (reg_i == RAW'(SR_IDX) && mode_i[1]) begin
      act_o  = A_CONST;
      cval_o = mode_i[0] ? DW'(8) : DW'(4);
    end else begin
      unique case (mode_i)
        2'd0: act_o = A_REG;
        2'd1: act_o = (reg_i == RAW'(SR_IDX)) ? A_ABS : A_IDX;
        2'd2: act_o = A_IND;
        default: act_o = (reg_i == RAW'(PC_IDX)) ? A_IMM : A_INC;
      endcase
    end
  end
endmodule

// File: rtl/opd_dst_decode.sv
module opd_dst_decode import opd_pkg::*; #(
  parameter int unsigned RAW = 4
) (
  input  logic [RAW-1:0] reg_i,
  input  logic           ind_i,
  output opd_act_e       act_o
);
  always_comb begin
    if (!ind_i)                        act_o = A_REG;
    else if (reg_i == RAW'(SR_IDX))    act_o = A_ABS;
    else                               act_o = A_IDX;
  end
endmodule

// File: rtl/operand_mode_decoder.sv
module operand_mode_decoder import opd_pkg::*; #(
  parameter int unsigned DW  = 16,
  parameter int unsigned RAW = 4
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           start_i,
  input  logic [15:0]    instr_i,
  output logic           busy_o,
  output logic           done_o,
  output logic [RAW-1:0] rf_raddr_o,
  input  logic [DW-1:0]  rf_rdata_i,
  output logic           rf_we_o,
  output logic [RAW-1:0] rf_waddr_o,
  output logic [DW-1:0]  rf_wdata_o,
  output logic           mem_req_o,
  output logic [DW-1:0]  mem_addr_o,
  input  logic           mem_rvalid_i,
  input  logic [DW-1:0]  mem_rdata_i,
  output logic [1:0]     src_kind_o,
  output logic [RAW-1:0] src_reg_o,
  output logic [DW-1:0]  src_val_o,
  output logic [1:0]     dst_kind_o,
  output logic [RAW-1:0] dst_reg_o,
  output logic [DW-1:0]  dst_addr_o,
  output logic           byte_o,
  output logic [DW-1:0]  dst_wmask_o
);
  localparam int unsigned IW = 16;
  localparam logic [DW-1:0] EXT_STEP  = DW'(2);
  localparam logic [DW-1:0] BYTE_MASK = {{(DW/2){1'b0}}, {(DW - DW/2){1'b1}}};

  typedef enum logic [2:0] {S_IDLE, S_SRC, S_SRC_W, S_DST, S_DST_W, S_DONE} st_e;

  st_e           st_q;
  logic [IW-1:0] ir_q;
  logic [DW-1:0] pc_q, base_q, src_val_q, dst_addr_q;
  opd_kind_e     src_kind_q, dst_kind_q;

  logic [RAW-1:0] sreg, dreg;
  logic [1:0]     smode;
  logic           dind, bw;
  assign sreg  = ir_q[8 +: RAW];
  assign dreg  = ir_q[0 +: RAW];
  assign smode = ir_q[5:4];
  assign dind  = ir_q[7];
  assign bw    = ir_q[6];

  opd_act_e      sact, dact;
  logic [DW-1:0] cval;

  opd_src_decode #(.DW(DW), .RAW(RAW)) u_src (
    .reg_i (sreg),
    .mode_i(smode),
    .act_o (sact),
    .cval_o(cval)
  );

  opd_dst_decode #(.RAW(RAW)) u_dst (
    .reg_i(dreg),
    .ind_i(dind),
    .act_o(dact)
  );

  // PC is served from the local copy so a pending write-back is never missed
  logic [DW-1:0] sbase, dbase, step;
  logic          s_ext, d_ext;
  assign sbase = (sreg == RAW'(PC_IDX)) ? pc_q : rf_rdata_i;
  assign dbase = (dreg == RAW'(PC_IDX)) ? pc_q : rf_rdata_i;
  assign step  = bw ? DW'(1) : DW'(2);
  assign s_ext = (sact == A_IDX) || (sact == A_ABS) || (sact == A_IMM);
  assign d_ext = (dact != A_REG);

  always_comb begin
    unique case (st_q)
      S_SRC, S_SRC_W: rf_raddr_o = sreg;
      S_DST, S_DST_W: rf_raddr_o = dreg;
      default:        rf_raddr_o = RAW'(PC_IDX);
    endcase
  end

  always_comb begin
    mem_req_o  = (st_q == S_SRC && s_ext) || (st_q == S_DST && d_ext);
    mem_addr_o = pc_q;
    rf_we_o    = 1'b0;
    rf_waddr_o = RAW'(PC_IDX);
    rf_wdata_o = pc_q + EXT_STEP;
    if (st_q == S_SRC && sact == A_INC) begin
      rf_we_o    = 1'b1;
      rf_waddr_o = sreg;
      rf_wdata_o = rf_rdata_i + step;
    end else if ((st_q == S_SRC_W || st_q == S_DST_W) && mem_rvalid_i) begin
      rf_we_o = 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q       <= S_IDLE;
      ir_q       <= '0;
      pc_q       <= '0;
      base_q     <= '0;
      src_val_q  <= '0;
      dst_addr_q <= '0;
      src_kind_q <= K_REG;
      dst_kind_q <= K_REG;
    end else begin
      unique case (st_q)
        S_IDLE: if (start_i) begin
          ir_q <= instr_i;
          pc_q <= rf_rdata_i;
          st_q <= S_SRC;
        end
        S_SRC: begin
          st_q <= S_DST;
          unique case (sact)
            A_REG: begin
              src_kind_q <= K_REG;
              src_val_q  <= '0;
            end
            A_CONST: begin
              src_kind_q <= K_CONST;
              src_val_q  <= cval;
            end
            A_IND, A_INC: begin
              src_kind_q <= K_MEM;
              src_val_q  <= sbase;
            end
            default: begin
              base_q <= (sact == A_ABS) ? '0 : sbase;
              st_q   <= S_SRC_W;
            end
          endcase
        end
        S_SRC_W: if (mem_rvalid_i) begin
          pc_q       <= pc_q + EXT_STEP;
          src_kind_q <= (sact == A_IMM) ? K_CONST : K_MEM;
          src_val_q  <= (sact == A_IMM) ? mem_rdata_i : base_q + mem_rdata_i;
          st_q       <= S_DST;
        end
        S_DST: begin
          if (d_ext) begin
            base_q <= (dact == A_ABS) ? '0 : dbase;
            st_q   <= S_DST_W;
          end else begin
            dst_kind_q <= K_REG;
            dst_addr_q <= '0;
            st_q       <= S_DONE;
          end
        end
        S_DST_W: if (mem_rvalid_i) begin
          pc_q       <= pc_q + EXT_STEP;
          dst_kind_q <= K_MEM;
          dst_addr_q <= base_q + mem_rdata_i;
          st_q       <= S_DONE;
        end
        default: st_q <= S_IDLE;
      endcase
    end
  end

  assign busy_o      = (st_q != S_IDLE);
  assign done_o      = (st_q == S_DONE);
  assign src_kind_o  = src_kind_q;
  assign src_reg_o   = sreg;
  assign src_val_o   = src_val_q;
  assign dst_kind_o  = dst_kind_q;
  assign dst_reg_o   = dreg;
  assign dst_addr_o  = dst_addr_q;
  assign byte_o      = bw;
  assign dst_wmask_o = (dst_kind_q == K_REG && bw) ? BYTE_MASK : '1;
endmodule

// File: rtl/opd_chk.sv
module opd_chk #(
  parameter int unsigned DW  = 16,
  parameter int unsigned RAW = 4
) (
  input logic           clk_i,
  input logic           rst_ni,
  input logic           start_i,
  input logic           busy_o,
  input logic           done_o,
  input logic [RAW-1:0] rf_raddr_o,
  input logic [DW-1:0]  rf_rdata_i,
  input logic           rf_we_o,
  input logic [RAW-1:0] rf_waddr_o,
  input logic [DW-1:0]  rf_wdata_o,
  input logic           mem_req_o,
  input logic [DW-1:0]  mem_addr_o,
  input logic           mem_rvalid_i,
  input logic           byte_o
);
  logic [DW-1:0] pc0_q;
  logic [1:0]    req_cnt, rv_cnt;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pc0_q   <= '0;
      req_cnt <= '0;
      rv_cnt  <= '0;
    end else if (start_i && !busy_o) begin
      pc0_q   <= rf_rdata_i;
      req_cnt <= '0;
      rv_cnt  <= '0;
    end else begin
      if (mem_req_o)              req_cnt <= req_cnt + 2'd1;
      if (mem_rvalid_i && busy_o) rv_cnt  <= rv_cnt + 2'd1;
    end
  end

  AST_EXT_ADDR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o |-> mem_addr_o == pc0_q + DW'({req_cnt, 1'b0}));  // R10
  AST_REQ_LIMIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o |-> req_cnt < 2'd2);  // R10
  AST_PC_ADVANCE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rf_we_o && rf_waddr_o == '0) |-> rf_wdata_o == pc0_q + DW'({rv_cnt, 1'b0}) + DW'(2));  // R10
  AST_AUTOINC_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rf_we_o && rf_waddr_o != '0) |->
      (rf_raddr_o == rf_waddr_o && rf_wdata_o == rf_rdata_i + (byte_o ? DW'(1) : DW'(2))));  // R4
  AST_DONE_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);  // R12
  AST_REQ_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o |-> (busy_o && !done_o));  // R12
endmodule

bind operand_mode_decoder opd_chk #(.DW(DW), .RAW(RAW)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .start_i     (start_i),
  .busy_o      (busy_o),
  .done_o      (done_o),
  .rf_raddr_o  (rf_raddr_o),
  .rf_rdata_i  (rf_rdata_i),
  .rf_we_o     (rf_we_o),
  .rf_waddr_o  (rf_waddr_o),
  .rf_wdata_o  (rf_wdata_o),
  .mem_req_o   (mem_req_o),
  .mem_addr_o  (mem_addr_o),
  .mem_rvalid_i(mem_rvalid_i),
  .byte_o      (byte_o)
);

// File: tb/sim_operand_mode_decoder.sv
`timescale 1ns/1ps
module sim_operand_mode_decoder;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #4 clk = ~clk;

  logic        start, busy, done, rf_we, mem_req, mem_rvalid, byte_sel;
  logic [15:0] instr, rf_rdata, rf_wdata, mem_addr, mem_rdata, src_val, dst_addr, wmask;
  logic [3:0]  rf_raddr, rf_waddr, src_reg, dst_reg;
  logic [1:0]  src_kind, dst_kind;

  operand_mode_decoder u0 (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .instr_i(instr),
    .busy_o(busy), .done_o(done),
    .rf_raddr_o(rf_raddr), .rf_rdata_i(rf_rdata),
    .rf_we_o(rf_we), .rf_waddr_o(rf_waddr), .rf_wdata_o(rf_wdata),
    .mem_req_o(mem_req), .mem_addr_o(mem_addr), .mem_rvalid_i(mem_rvalid), .mem_rdata_i(mem_rdata),
    .src_kind_o(src_kind), .src_reg_o(src_reg), .src_val_o(src_val),
    .dst_kind_o(dst_kind), .dst_reg_o(dst_reg), .dst_addr_o(dst_addr),
    .byte_o(byte_sel), .dst_wmask_o(wmask)
  );

  function automatic logic [15:0] rf_init(int i);
    return (i == 0) ? 16'h0020 : 16'(i) * 16'h0111;
  endfunction
  function automatic logic [15:0] ext_word(logic [15:0] a);
    return a ^ 16'h5A00;
  endfunction

  // register file and memory models
  logic [15:0] rf [16];
  logic [15:0] mem [256];
  assign rf_rdata = rf[rf_raddr];
  initial for (int i = 0; i < 256; i++) mem[i] = ext_word(16'(i * 2));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) for (int i = 0; i < 16; i++) rf[i] <= rf_init(i);
    else if (rf_we) rf[rf_waddr] <= rf_wdata;
  end

  int lat = 1;
  int cnt;
  logic [7:0] paddr;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= 0; mem_rvalid <= 1'b0; mem_rdata <= '0; paddr <= '0;
    end else begin
      mem_rvalid <= 1'b0;
      if (mem_req) begin
        cnt <= lat; paddr <= mem_addr[8:1];
      end else if (cnt != 0) begin
        cnt <= cnt - 1;
        if (cnt == 1) begin mem_rvalid <= 1'b1; mem_rdata <= mem[paddr]; end
      end
    end
  end

  // scoreboard
  typedef struct packed {
    logic [1:0]        sk;
    logic [15:0]       sv;
    logic [3:0]        sr;
    logic [1:0]        dk;
    logic [15:0]       da;
    logic [3:0]        dr;
    logic [15:0]       mask;
    logic [15:0][15:0] regs;
  } exp_t;
  exp_t  q[$];
  string tq[$];
  logic [15:0] mreg [16];
  int nchk = 0, nerr = 0, nissue = 0, ndone = 0;
  bit finished = 0;

  task automatic chk(input string tag, input string what, input logic [15:0] act, input logic [15:0] exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s %s: got %h exp %h", tag, what, act, exp);
    end
  endtask

  function automatic logic [15:0] mk(int sr, int ad, int bw, int as, int dr);
    return {4'h4, 4'(sr), 1'(ad), 1'(bw), 2'(as), 4'(dr)};
  endfunction

  task automatic issue(input logic [15:0] ins, input string tag, input bit poke);
    exp_t e;
    logic [3:0] sr, dr;
    logic [1:0] as;
    logic bw, ad;
    logic [15:0] pc, x;
    // R2: field positions used by the model
    sr = ins[11:8]; as = ins[5:4]; dr = ins[3:0]; ad = ins[7]; bw = ins[6];
    pc = mreg[0];
    e = '0; e.sr = sr; e.dr = dr;
    if (sr == 4'd3) begin
      e.sk = 2'd1;
      e.sv = (as == 0) ? 16'h0 : (as == 1) ? 16'h1 : (as == 2) ? 16'h2 : 16'hFFFF;
    end else if (sr == 4'd2 && as >= 2) begin
      e.sk = 2'd1; e.sv = (as == 2) ? 16'h4 : 16'h8;
    end else if (as == 0) begin
      e.sk = 2'd0; e.sv = 16'h0;
    end else if (as == 1) begin
      x = ext_word(pc); e.sk = 2'd2;
      e.sv = ((sr == 4'd2) ? 16'h0 : mreg[sr]) + x;
      pc = pc + 16'd2;
    end else if (as == 3 && sr == 4'd0) begin
      e.sk = 2'd1; e.sv = ext_word(pc); pc = pc + 16'd2;
    end else begin
      e.sk = 2'd2; e.sv = mreg[sr];
      if (as == 3) mreg[sr] = mreg[sr] + (bw ? 16'd1 : 16'd2);
    end
    mreg[0] = pc;
    if (ad) begin
      x = ext_word(pc); e.dk = 2'd2;
      e.da = ((dr == 4'd2) ? 16'h0 : (dr == 4'd0) ? pc : mreg[dr]) + x;
      pc = pc + 16'd2;
    end else begin
      e.dk = 2'd0; e.da = 16'h0;
    end
    mreg[0] = pc;
    e.mask = (!ad && bw) ? 16'h00FF : 16'hFFFF;
    for (int r = 0; r < 16; r++) e.regs[r] = mreg[r];
    q.push_back(e); tq.push_back(tag); nissue++;
    @(negedge clk); instr = ins; start = 1'b1;
    @(negedge clk); start = 1'b0;
    if (poke) begin
      instr = 16'h4335; start = 1'b1;
      @(negedge clk); start = 1'b0;
    end
    while (busy) @(negedge clk);
  endtask

  // monitor
  initial begin
    forever begin
      @(negedge clk);
      if (rst_n && done) begin
        ndone++;
        if (q.size() == 0) begin
          nchk++; nerr++;
          $display("FAIL R12 unexpected done: got 1 exp 0");
        end else begin
          exp_t  e;
          string t;
          e = q.pop_front(); t = tq.pop_front();
          chk(t, "src_kind", 16'(src_kind), 16'(e.sk));
          chk(t, "src_val", src_val, e.sv);
          chk("R2", "src_reg", 16'(src_reg), 16'(e.sr));
          chk(t, "dst_kind", 16'(dst_kind), 16'(e.dk));
          chk(t, "dst_addr", dst_addr, e.da);
          chk("R2", "dst_reg", 16'(dst_reg), 16'(e.dr));
          chk("R11", "wmask", wmask, e.mask);
          chk("R10", "pc", rf[0], e.regs[0]);
          for (int r = 1; r < 16; r++) chk("R4", "reg", rf[r], e.regs[r]);
          @(negedge clk);
          chk("R12", "done pulse", 16'(done), 16'h0);
        end
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      nchk++; nerr++;
      $display("FAIL R12 watchdog: got hung exp done");
      $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
      $finish;
    end
  end

  initial begin
    start = 1'b0; instr = '0;
    for (int i = 0; i < 16; i++) mreg[i] = rf_init(i);
    repeat (3) @(negedge clk);
    chk("R1", "busy in reset", 16'(busy), 16'h0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1", "busy", 16'(busy), 16'h0);
    chk("R1", "done", 16'(done), 16'h0);
    chk("R1", "mem_req", 16'(mem_req), 16'h0);
    chk("R1", "rf_we", 16'(rf_we), 16'h0);

    issue(mk(5, 0, 0, 0, 6), "R3", 0);
    issue(mk(5, 0, 1, 2, 7), "R11", 0);
    issue(mk(9, 0, 0, 2, 4), "R3", 0);
    issue(mk(6, 1, 0, 3, 6), "R13", 0);
    issue(mk(7, 0, 1, 3, 8), "R4", 0);
    issue(mk(1, 0, 0, 3, 5), "R4", 0);
    issue(mk(8, 1, 0, 1, 9), "R5", 0);
    lat = 3;
    issue(mk(12, 1, 0, 1, 13), "R2", 0);
    for (int a = 0; a < 4; a++) issue(mk(3, 0, 0, a, 10), "R6", 0);
    for (int a = 0; a < 4; a++) issue(mk(2, 0, 0, a, 11), "R7", 0);
    issue(mk(2, 1, 0, 1, 2), "R7", 0);
    lat = 1;
    issue(mk(0, 1, 0, 1, 0), "R8", 0);
    issue(mk(0, 1, 0, 3, 4), "R8", 0);
    issue(mk(0, 0, 0, 2, 5), "R3", 0);
    issue(mk(4, 1, 1, 1, 0), "R9", 0);
    issue(mk(10, 1, 0, 0, 2), "R9", 0);
    issue(mk(11, 1, 0, 0, 14), "R10", 0);
    lat = 3;
    issue(mk(8, 1, 0, 1, 12), "R12", 1);
    repeat (4) @(negedge clk);
    chk("R12", "done count", 16'(ndone), 16'(nissue));
    chk("R12", "queue empty", 16'(q.size()), 16'h0);
    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  end
endmodule